// File: doc/BRIEF.md
# Serial SRAM Burst Controller

This block is an SPI master that moves bursts of bytes to and from an external serial SRAM in sequential mode. A user asks for a transfer by pulsing a request with a direction, a 24-bit start address and a byte count. The block lowers chip select and shifts out a command byte followed by the start address. It then runs the data phase and raises chip select again. Write bytes come in on a valid/ready byte stream, and read bytes leave on a second valid/ready byte stream.

The serial clock is derived from the system clock. Each serial clock level lasts `HALF_CYC` system clocks, so the smallest ratio is 2. The block never lets a byte be lost. If a write byte is late, or if the read consumer has not taken the previous byte, the serial clock waits low and chip select stays asserted. The memory itself advances and wraps the address inside a burst, so the block only ever sends the start address.

Top module: `sram_burst_master`

## Requirements
- R1: While reset is held and after it is released, chip select is high, the serial clock is low, MOSI is low, `busy`, `rd_valid` and `wr_ready` are low.
- R2: The first byte after chip select falls is the command: 8'h02 for a write request, 8'h03 for a read request. Each byte is shifted most significant bit first.
- R3: The serial clock is low whenever chip select is high. MOSI changes only while the serial clock is low, and MISO is captured at the rising serial clock edge (mode 0).
- R4: The three bytes after the command carry the 24-bit start address, with bits 23:16 first, then 15:8, then 7:0.
- R5: In a write, exactly `req_len` bytes follow the address, each taken by a `wr_valid`/`wr_ready` handshake and sent in the order taken.
- R6: In a read, exactly `req_len` bytes are clocked in after the address and delivered in order on `rd_data`. MOSI is held low during the read data phase.
- R7: `busy` rises on the cycle after an accepted request and falls in the same cycle that chip select returns high. Requests presented while `busy` is high are ignored and start no frame.
- R8: Chip select stays high for at least 2*`HALF_CYC` system clocks between frames.
- R9: If no write byte is valid when the next byte could start, the serial clock stays low, chip select stays low, and `wr_ready` stays high until a byte arrives.
- R10: While `rd_valid` is high and `rd_ready` is low, `rd_data` holds its value and no further serial clock edges occur.
- R11: A byte count of zero sends the command and the address, then ends the frame without a data phase.
- R12: Each high level of the serial clock lasts exactly `HALF_CYC` system clocks, and each low level inside a frame lasts at least `HALF_CYC` system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a burst (taken when not busy) |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_addr | input | ADDR_W | Burst start address |
| req_len | input | LEN_W | Number of data bytes in the burst |
| busy | output | 1 | Burst in progress |
| wr_data | input | 8 | Write byte |
| wr_valid | input | 1 | Write byte available |
| wr_ready | output | 1 | Block takes the write byte this cycle |
| rd_data | output | 8 | Read byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Consumer takes the read byte |
| sram_cs_n | output | 1 | Chip select, active low |
| sram_sclk | output | 1 | Serial clock |
| sram_mosi | output | 1 | Serial data to memory |
| sram_miso | input | 1 | Serial data from memory |

## Verification
The bench attaches a bit-level memory model that decodes each frame. A scoreboard compares the command, the address, the bit count and every byte against queued expectations.

The direction logic is exercised with writes and reads that use distinct byte patterns. A start address just below the top of the space tells address sequencing apart from wraparound.

A zero count separates the header path from the data path. A write byte held back in mid-burst shows that the clock pauses rather than shifting a stale byte. A read consumer that withholds `rd_ready` shows that a byte is neither dropped nor overwritten.

A request arriving during a burst, together with the measured chip-select gaps and clock levels, covers the framing rules.

// File: rtl/sbm_pkg.sv
package sbm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HDR,
    ST_DATA,
    ST_HOLD
  } sbm_state_t;

  localparam logic [7:0] CMD_WRITE = 8'h02;
  localparam logic [7:0] CMD_READ  = 8'h03;

endpackage

// File: rtl/sbm_byte_engine.sv
// Shifts one byte each way, MSB first, in SPI mode 0.
module sbm_byte_engine #(
  parameter int HALF_CYC = 2,
  parameter int BYTE_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              miso,
  output logic              active,
  output logic              done,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              sclk,
  output logic              mosi
);

  localparam int CW = $clog2(HALF_CYC + 1);
  localparam int BW = $clog2(BYTE_W);
  localparam logic [CW-1:0] CNT_LOAD = CW'(HALF_CYC - 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(BYTE_W - 1);

  logic              phase_hi;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bit_idx;
  logic [BYTE_W-1:0] txsh;
  logic [BYTE_W-1:0] rxsh;

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      done     <= 1'b0;
      phase_hi <= 1'b0;
      cnt      <= '0;
      bit_idx  <= '0;
      txsh     <= '0;
      rxsh     <= '0;
      rx_byte  <= '0;
      sclk     <= 1'b0;
      mosi     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !active) begin
        active   <= 1'b1;
        phase_hi <= 1'b0;
        cnt      <= CNT_LOAD;
        bit_idx  <= BIT_LAST;
        txsh     <= tx_byte;
        mosi     <= tx_byte[BYTE_W-1];
      end else if (active) begin
        if (cnt != '0) begin
          cnt <= cnt - 1'b1;
        end else begin
          cnt <= CNT_LOAD;
          if (!phase_hi) begin
            sclk     <= 1'b1;
            phase_hi <= 1'b1;
            rxsh     <= {rxsh[BYTE_W-2:0], miso};
          end else begin
            sclk     <= 1'b0;
            phase_hi <= 1'b0;
            if (bit_idx == '0) begin
              active  <= 1'b0;
              done    <= 1'b1;
              rx_byte <= rxsh;
              mosi    <= 1'b0;
            end else begin
              bit_idx <= bit_idx - 1'b1;
              txsh    <= {txsh[BYTE_W-2:0], 1'b0};
              mosi    <= txsh[BYTE_W-2];
            end
          end
        end
      end
    end
  end

  // Checker state: length of the current high level of sclk.
  logic [CW:0] hi_len;
  always_ff @(posedge clk) begin
    if (rst)                       hi_len <= '0;
    else if (!sclk)                hi_len <= '0;
    else if (hi_len != '1)         hi_len <= hi_len + 1'b1;
  end

  a_r12_high_level_len: assert property (@(posedge clk) disable iff (rst)
    $fell(sclk) |-> (hi_len == (CW+1)'(HALF_CYC)));

  a_r3_mosi_steady_high: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(mosi));

endmodule

// File: rtl/sbm_cs_gap.sv
// Counts the chip-select high time and releases the next frame.
module sbm_cs_gap #(
  parameter int GAP_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  output logic gap_ok
);

  localparam int GW = $clog2(GAP_CYC + 1);
  localparam logic [GW-1:0] GAP_LOAD = GW'(GAP_CYC - 1);

  logic [GW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= GAP_LOAD;
    else if (!cs_n)       cnt <= GAP_LOAD;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign gap_ok = (cnt == '0);

endmodule

// File: rtl/sram_burst_master.sv
module sram_burst_master
  import sbm_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int LEN_W    = 17,
  parameter int HALF_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              busy,
  input  logic [7:0]        wr_data,
  input  logic              wr_valid,
  output logic              wr_ready,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic              sram_cs_n,
  output logic              sram_sclk,
  output logic              sram_mosi,
  input  logic              sram_miso
);

  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int HDR_BYTES  = ADDR_BYTES + 1;
  localparam int IDXW       = $clog2(HDR_BYTES);
  localparam int GAP_CYC    = 2 * HALF_CYC;
  localparam int CW         = $clog2(HALF_CYC + 1);
  localparam logic [IDXW-1:0] IDX_LAST = IDXW'(HDR_BYTES - 1);

  sbm_state_t        state;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  remain;
  logic [IDXW-1:0]   hdr_idx;
  logic [IDXW-1:0]   hdr_nxt;
  logic [CW-1:0]     hold_cnt;

  logic       eng_start, eng_active, eng_done;
  logic [7:0] eng_tx, eng_rx;
  logic       eng_idle, gap_ok;
  logic       lead_go, hdr_next, data_slot, rd_go;

  // Header bytes: command, then address bytes from the high end down.
  logic [7:0] hdr_bytes [HDR_BYTES];
  assign hdr_bytes[0] = wr_q ? CMD_WRITE : CMD_READ;
  for (genvar gi = 1; gi < HDR_BYTES; gi++) begin : g_addr_byte
    assign hdr_bytes[gi] = addr_q[ADDR_W-8*(gi-1)-1 -: 8];
  end

  assign hdr_nxt   = hdr_idx + 1'b1;
  assign eng_idle  = !eng_active && !eng_done;
  assign lead_go   = (state == ST_LEAD) && gap_ok;
  assign hdr_next  = (state == ST_HDR) && eng_done && (hdr_idx != IDX_LAST);
  assign data_slot = (state == ST_DATA) && eng_idle && (remain != '0);
  assign wr_ready  = data_slot && wr_q;
  assign rd_go     = data_slot && !wr_q && !rd_valid;
  assign eng_start = lead_go || hdr_next || (wr_ready && wr_valid) || rd_go;

  always_comb begin
    if (lead_go)       eng_tx = hdr_bytes[0];
    else if (hdr_next) eng_tx = hdr_bytes[hdr_nxt];
    else if (wr_q)     eng_tx = wr_data;
    else               eng_tx = 8'h00;
  end

  sbm_byte_engine #(
    .HALF_CYC (HALF_CYC),
    .BYTE_W   (8)
  ) u_engine (
    .clk     (clk),
    .rst     (rst),
    .start   (eng_start),
    .tx_byte (eng_tx),
    .miso    (sram_miso),
    .active  (eng_active),
    .done    (eng_done),
    .rx_byte (eng_rx),
    .sclk    (sram_sclk),
    .mosi    (sram_mosi)
  );

  sbm_cs_gap #(
    .GAP_CYC (GAP_CYC)
  ) u_gap (
    .clk    (clk),
    .rst    (rst),
    .cs_n   (sram_cs_n),
    .gap_ok (gap_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      busy      <= 1'b0;
      wr_q      <= 1'b0;
      addr_q    <= '0;
      len_q     <= '0;
      remain    <= '0;
      hdr_idx   <= '0;
      hold_cnt  <= '0;
      sram_cs_n <= 1'b1;
      rd_data   <= '0;
      rd_valid  <= 1'b0;
    end else begin
      if (rd_valid && rd_ready) rd_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            wr_q   <= req_write;
            addr_q <= req_addr;
            len_q  <= req_len;
            busy   <= 1'b1;
            state  <= ST_LEAD;
          end
        end
        ST_LEAD: begin
          if (gap_ok) begin
            sram_cs_n <= 1'b0;
            hdr_idx   <= '0;
            state     <= ST_HDR;
          end
        end
        ST_HDR: begin
          if (eng_done) begin
            if (hdr_idx == IDX_LAST) begin
              remain <= len_q;
              state  <= ST_DATA;
            end else begin
              hdr_idx <= hdr_nxt;
            end
          end
        end
        ST_DATA: begin
          if (eng_start) remain <= remain - 1'b1;
          if (eng_done && !wr_q) begin
            rd_data  <= eng_rx;
            rd_valid <= 1'b1;
          end
          if (remain == '0 && eng_idle) begin
            hold_cnt <= CW'(HALF_CYC - 1);
            state    <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (hold_cnt == '0) begin
            sram_cs_n <= 1'b1;
            busy      <= 1'b0;
            state     <= ST_IDLE;
          end else begin
            hold_cnt <= hold_cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Checker state: cycles chip select has been high.
  localparam int HW = $clog2(GAP_CYC + 1) + 1;
  logic [HW-1:0] hi_run;
  always_ff @(posedge clk) begin
    if (rst)                hi_run <= '0;
    else if (!sram_cs_n)    hi_run <= '0;
    else if (hi_run != '1)  hi_run <= hi_run + 1'b1;
  end

  a_r3_sclk_low_when_deselected: assert property (@(posedge clk) disable iff (rst)
    sram_cs_n |-> !sram_sclk);

  a_r7_busy_ends_with_cs: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $rose(sram_cs_n));

  a_r7_no_frame_when_idle: assert property (@(posedge clk) disable iff (rst)
    !busy |-> sram_cs_n);

  a_r8_cs_gap: assert property (@(posedge clk) disable iff (rst)
    $fell(sram_cs_n) |-> (hi_run >= HW'(GAP_CYC)));

  a_r9_stall_holds_clock: assert property (@(posedge clk) disable iff (rst)
    (wr_ready && !wr_valid) |=> (!sram_sclk && !sram_cs_n && wr_ready));

  a_r10_read_hold: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  a_r6_mosi_low_in_read: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DATA && !wr_q && sram_sclk) |-> !sram_mosi);

endmodule

// File: tb/sram_burst_master_bench.sv
module sram_burst_master_bench;

  localparam int CLK_P = 10;
  localparam int HALF  = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [23:0] req_addr  = '0;
  logic [16:0] req_len   = '0;
  logic        busy;
  logic [7:0]  wr_data   = '0;
  logic        wr_valid  = 1'b0;
  logic        wr_ready;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic        rd_ready  = 1'b1;
  logic        sram_cs_n, sram_sclk, sram_mosi;
  logic        sram_miso = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  sram_burst_master #(
    .ADDR_W   (24),
    .LEN_W    (17),
    .HALF_CYC (HALF)
  ) u_sram_burst_master (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_len   (req_len),
    .busy      (busy),
    .wr_data   (wr_data),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .sram_cs_n (sram_cs_n),
    .sram_sclk (sram_sclk),
    .sram_mosi (sram_mosi),
    .sram_miso (sram_miso)
  );

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Scoreboard queues
  logic [7:0]  hop_q [$];
  logic [23:0] hadr_q [$];
  int          hlen_q [$];
  logic [7:0]  wexp_q [$];
  logic [7:0]  rexp_q [$];
  logic [7:0]  ref_mem [logic [23:0]];

  // Memory model on the serial side
  logic [7:0]  smem [logic [23:0]];
  int          s_bits = 0;
  logic [7:0]  s_sh = '0, s_op = '0;
  logic [23:0] s_adr = '0;
  bit          in_frame = 0;
  int          frames = 0;
  int          mosi_bad = 0;

  always @(negedge sram_cs_n) begin
    in_frame = 1;
    s_bits = 0; s_op = '0; s_adr = '0; sram_miso = 1'b0;
  end

  always @(posedge sram_cs_n) begin
    if (in_frame) begin
      in_frame = 0;
      frames++;
      if (hop_q.size() == 0) begin
        chk(0, "R7 unexpected frame", 32'(s_op), 0);
      end else begin
        logic [7:0]  eop;
        logic [23:0] ead;
        int          eln;
        eop = hop_q.pop_front();
        ead = hadr_q.pop_front();
        eln = hlen_q.pop_front();
        chk(s_op == eop, "R2 command byte", 32'(s_op), 32'(eop));
        chk(s_adr == ead, "R4 start address", 32'(s_adr), 32'(ead));
        chk(s_bits == 32 + 8*eln, (eln == 0) ? "R11 header-only bit count" : "R5 R6 frame bit count",
            32'(s_bits), 32'(32 + 8*eln));
      end
    end
  end

  always @(posedge sram_sclk) begin
    if (in_frame) begin
      s_sh = {s_sh[6:0], sram_mosi};
      s_bits++;
      if (s_op == 8'h03 && s_bits > 32 && sram_mosi !== 1'b0) mosi_bad++;
      if (s_bits % 8 == 0) begin
        int idx;
        logic [23:0] a;
        idx = s_bits/8 - 1;
        case (idx)
          0: s_op = s_sh;
          1: s_adr[23:16] = s_sh;
          2: s_adr[15:8]  = s_sh;
          3: s_adr[7:0]   = s_sh;
          default: begin
            if (s_op == 8'h02) begin
              a = s_adr + 24'(idx - 4);
              smem[a] = s_sh;
              if (wexp_q.size() == 0) chk(0, "R5 unexpected write byte", 32'(s_sh), 0);
              else begin
                logic [7:0] e;
                e = wexp_q.pop_front();
                chk(s_sh == e, "R5 write byte", 32'(s_sh), 32'(e));
              end
            end
          end
        endcase
      end
    end
  end

  always @(negedge sram_sclk) begin
    if (in_frame && s_op == 8'h03 && s_bits >= 32) begin
      int k;
      logic [23:0] a;
      logic [7:0]  b;
      k = s_bits - 32;
      a = s_adr + 24'(k/8);
      b = smem.exists(a) ? smem[a] : 8'hA5;
      sram_miso = b[7 - (k % 8)];
    end
  end

  // Read-stream monitor
  always @(negedge clk) begin
    if (!rst && rd_valid && rd_ready) begin
      if (rexp_q.size() == 0) chk(0, "R6 unexpected read byte", 32'(rd_data), 0);
      else begin
        logic [7:0] e;
        e = rexp_q.pop_front();
        chk(rd_data == e, "R6 read byte", 32'(rd_data), 32'(e));
      end
    end
  end

  // Line timing monitor
  int  idle_bad = 0, stab_bad = 0;
  int  hi_len = 0, hi_min = 1000, hi_max = 0;
  int  lo_len = 0, lo_min = 1000;
  int  gap_len = 0, gap_min = 1000;
  bit  seen_frame = 0;
  logic p_sclk = 1'b0, p_mosi = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (sram_cs_n && sram_sclk) idle_bad++;
      if (sram_sclk && p_sclk && sram_mosi !== p_mosi) stab_bad++;
      if (sram_sclk) begin
        hi_len++;
        if (lo_len > 0 && lo_len < lo_min) lo_min = lo_len;
        lo_len = 0;
      end else begin
        if (hi_len > 0) begin
          if (hi_len < hi_min) hi_min = hi_len;
          if (hi_len > hi_max) hi_max = hi_len;
        end
        hi_len = 0;
        if (!sram_cs_n) lo_len++;
        else lo_len = 0;
      end
      if (sram_cs_n) gap_len++;
      else begin
        if (seen_frame && gap_len > 0 && gap_len < gap_min) gap_min = gap_len;
        seen_frame = 1;
        gap_len = 0;
      end
      p_sclk = sram_sclk;
      p_mosi = sram_mosi;
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wait_idle();
    forever begin
      @(negedge clk);
      if (!busy) break;
    end
    step();
  endtask

  task automatic start_req(input bit wr, input logic [23:0] a, input int n);
    hop_q.push_back(wr ? 8'h02 : 8'h03);
    hadr_q.push_back(a);
    hlen_q.push_back(n);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_len = 17'(n);
    step();
    req_valid = 1'b0;
    chk(busy == 1'b1, "R7 busy after accept", 32'(busy), 1);
  endtask

  task automatic do_write(input logic [23:0] a, input int n, input logic [7:0] seed, input int stall_at);
    start_req(1'b1, a, n);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = seed + 8'(i * 7);
      wexp_q.push_back(b);
      ref_mem[a + 24'(i)] = b;
      if (i == stall_at) begin
        wr_valid = 1'b0;
        repeat (40) step();
        @(negedge clk);
        chk({sram_sclk, sram_cs_n, busy, wr_ready} == 4'b0011, "R9 paused on missing byte",
            32'({sram_sclk, sram_cs_n, busy, wr_ready}), 32'b0011);
        step();
      end
      wr_valid = 1'b1;
      wr_data  = b;
      forever begin
        @(negedge clk);
        if (wr_ready) break;
      end
      step();
    end
    wr_valid = 1'b0;
    wait_idle();
  endtask

  task automatic do_read(input logic [23:0] a, input int n, input bit stall);
    for (int i = 0; i < n; i++) begin
      logic [23:0] x;
      x = a + 24'(i);
      rexp_q.push_back(ref_mem.exists(x) ? ref_mem[x] : 8'hA5);
    end
    if (stall) rd_ready = 1'b0;
    start_req(1'b0, a, n);
    if (stall) begin
      logic [7:0] d;
      bit ok;
      forever begin
        @(negedge clk);
        if (rd_valid) break;
      end
      d = rd_data;
      ok = 1;
      repeat (30) begin
        @(negedge clk);
        if (!rd_valid || rd_data != d || sram_sclk) ok = 0;
      end
      chk(ok, "R10 read byte held under backpressure", 32'(ok), 1);
      step();
      rd_ready = 1'b1;
    end
    wait_idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R7 watchdog: busy actual %0d expected 0", busy);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (4) step();
    @(negedge clk);
    chk({sram_cs_n, sram_sclk, sram_mosi, busy, rd_valid, wr_ready} == 6'b100000,
        "R1 state in reset", 32'({sram_cs_n, sram_sclk, sram_mosi, busy, rd_valid, wr_ready}), 32'b100000);
    step();
    rst = 1'b0;
    repeat (3) step();
    @(negedge clk);
    chk({sram_cs_n, sram_sclk, sram_mosi, busy, rd_valid, wr_ready} == 6'b100000,
        "R1 state after reset", 32'({sram_cs_n, sram_sclk, sram_mosi, busy, rd_valid, wr_ready}), 32'b100000);
    step();

    // Plain write then read back (R2 R4 R5 R6)
    do_write(24'h000010, 4, 8'h11, -1);
    do_read (24'h000010, 4, 1'b0);

    // Zero-length bursts (R11)
    do_write(24'h000040, 0, 8'h00, -1);
    do_read (24'h000040, 0, 1'b0);

    // Burst crossing the top of the address space
    do_write(24'hFFFFFE, 4, 8'h80, -1);
    do_read (24'hFFFFFE, 4, 1'b0);

    // Write stall (R9) and read backpressure (R10)
    do_write(24'h001000, 5, 8'h33, 2);
    do_read (24'h001000, 5, 1'b1);

    // Request during a burst is ignored (R7)
    begin
      int f0;
      f0 = frames;
      for (int i = 0; i < 2; i++) rexp_q.push_back(ref_mem[24'h000010 + 24'(i)]);
      start_req(1'b0, 24'h000010, 2);
      repeat (5) step();
      req_valid = 1'b1; req_write = 1'b1; req_addr = 24'h000200; req_len = 17'd3;
      step();
      req_valid = 1'b0;
      wait_idle();
      repeat (10) step();
      chk(frames == f0 + 1, "R7 request while busy ignored", 32'(frames), 32'(f0 + 1));
      chk(busy == 1'b0, "R7 busy low after frame", 32'(busy), 0);
    end

    // Longer burst with a varied pattern
    do_write(24'h000300, 10, 8'hC4, -1);
    do_read (24'h000300, 10, 1'b0);

    repeat (10) step();
    chk(idle_bad == 0, "R3 clock low while deselected", 32'(idle_bad), 0);
    chk(stab_bad == 0, "R3 MOSI steady while clock high", 32'(stab_bad), 0);
    chk(mosi_bad == 0, "R6 MOSI low in read data phase", 32'(mosi_bad), 0);
    chk(hi_min == HALF && hi_max == HALF, "R12 clock high level length", 32'(hi_max), 32'(HALF));
    chk(lo_min >= HALF, "R12 clock low level length", 32'(lo_min), 32'(HALF));
    chk(gap_min >= 2*HALF, "R8 chip select gap", 32'(gap_min), 32'(2*HALF));
    chk(rexp_q.size() == 0, "R6 all read bytes delivered", 32'(rexp_q.size()), 0);
    chk(wexp_q.size() == 0, "R5 all write bytes sent", 32'(wexp_q.size()), 0);
    chk(hop_q.size() == 0, "R7 all frames seen", 32'(hop_q.size()), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule